// File: doc/BRIEF.md
# Two-Stage Template Correlation Search

This block finds where a small grayscale template best fits inside a larger grayscale image. Both pictures live in on-chip memories outside the block. The block drives a read address into each memory and takes the byte that comes back one cycle later. For every candidate offset it multiplies each template byte by the image byte under it and sums the products. It then keeps the largest sum seen so far and the offset where that sum occurred.

A search starts with a one-cycle start pulse and has two passes. The first pass visits offsets on a sparse grid whose pitch is `COARSE_STEP`. The second pass visits every one-pixel offset inside a square window around the best grid point, and the window is clipped so that the template always stays inside the image. At the end the block raises `done` for one cycle and presents the winning offset, its score and a match flag. The flag compares the score with a threshold that was taken at start. The block has no streaming port. Its memory side uses plain address and data pins with a fixed one-cycle read latency, so it needs no back-pressure and accepts no stall.

Top module: `tmatch_top`

## Requirements
- R1: Image and template pixels are unsigned 8-bit values. The score of an offset (x,y) is the sum, over template positions (u,v), of image(x+u, y+v) × template(u,v). The accumulator is `16 + clog2(TPL_W*TPL_H+1)` bits wide, so it never wraps, even when every pixel is 255.
- R2: Both memories are row-major. The image address is `(y+v)*IMG_W + (x+u)` and the template address is `v*TPL_W + u`. Read data is used on the cycle after its address is driven. While busy, no address leaves its memory's range.
- R3: The coarse pass scores offsets whose x and y are multiples of `COARSE_STEP`, with x ≤ IMG_W−TPL_W and y ≤ IMG_H−TPL_H. It visits them row by row, left to right, and spends TPL_W×TPL_H cycles on each offset with no gap between offsets.
- R4: The fine pass scores every offset with x in [bx−FINE_RAD, bx+FINE_RAD] and y in [by−FINE_RAD, by+FINE_RAD], where (bx,by) is the coarse winner. Each range is clipped to [0, IMG_W−TPL_W] and [0, IMG_H−TPL_H]. Offsets are visited in raster order. `done` is high in cycle TPL_W×TPL_H×(coarse count + fine count) + 7 after the start edge.
- R5: The reported offset and peak are the running maximum over the coarse scan followed by the fine scan. The maximum starts at score 0 at offset (0,0). A later score replaces it only if it is strictly greater, so on a tie the earlier offset wins.
- R6: `match` is 1 exactly when the peak is greater than or equal to the `match_thresh` value captured on the accepted start.
- R7: A start pulse while `busy` is high is ignored, including a pulse in the cycle where `done` is high. The running search is not disturbed, and no new search follows.
- R8: `busy` rises in the cycle after an accepted start and stays high through the single cycle in which `done` is high. It falls in the next cycle.
- R9: `best_x`, `best_y`, `peak` and `match` hold their values from `done` until the next accepted start.
- R10: After reset, `busy`, `done`, `best_x`, `best_y`, `peak` and `match` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a search |
| match_thresh | input | ACC_W | Score threshold, captured on an accepted start |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse: results are final |
| img_addr | output | IAW | Image memory read address |
| img_data | input | 8 | Image byte, one cycle after its address |
| tpl_addr | output | TAW | Template memory read address |
| tpl_data | input | 8 | Template byte, one cycle after its address |
| best_x | output | XW | Column of the best offset |
| best_y | output | YW | Row of the best offset |
| peak | output | ACC_W | Score at the best offset |
| match | output | 1 | Peak is at or above the captured threshold |

## Verification
Two events can meet in one cycle: the completion pulse and a fresh start request. The block must let the pulse through and drop the request. The bench first times a run on a fixed image. It then repeats that run and raises `start` in exactly the cycle the timing predicts for `done`. It then checks that `busy` falls on the next cycle, that no second `done` appears, and that the results stay frozen. A second case lands a start in the middle of a run and checks that the start-to-done latency and the results match the undisturbed run.

// File: rtl/tmatch_pkg.sv
package tmatch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COARSE,
    ST_CDRAIN,
    ST_FINE,
    ST_FDRAIN,
    ST_DONE
  } tm_state_e;

  localparam int PIX_W = 8;
  localparam int DRAIN_LAST = 2;
endpackage

// File: rtl/tmatch_scan.sv
module tmatch_scan
  import tmatch_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 12,
  parameter int TPL_W = 4,
  parameter int TPL_H = 3,
  parameter int COARSE_STEP = 4,
  parameter int FINE_RAD = 2,
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int IAW = 8,
  parameter int TAW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [XW-1:0]  best_x,
  input  logic [YW-1:0]  best_y,
  output logic           busy,
  output logic           done,
  output logic           clr,
  output logic           seal,
  output logic           iss_vld,
  output logic           iss_last,
  output logic [XW-1:0]  iss_x,
  output logic [YW-1:0]  iss_y,
  output logic [IAW-1:0] img_addr,
  output logic [TAW-1:0] tpl_addr
);
  localparam int MAX_OX = IMG_W - TPL_W;
  localparam int MAX_OY = IMG_H - TPL_H;
  localparam int TXW = $clog2(TPL_W + 1);
  localparam int TYW = $clog2(TPL_H + 1);

  tm_state_e      st;
  logic [XW-1:0]  ox, xlo, xhi, stx, nx, fxlo, fxhi;
  logic [YW-1:0]  oy, yhi, sty, ny, fylo, fyhi;
  logic [TXW-1:0] tx;
  logic [TYW-1:0] ty;
  logic [1:0]     dcnt;
  logic           coarse, issuing, tpl_end, row_end, grid_end;

  always_comb begin
    coarse   = (st == ST_COARSE);
    issuing  = coarse || (st == ST_FINE);
    stx      = coarse ? XW'(COARSE_STEP) : XW'(1);
    sty      = coarse ? YW'(COARSE_STEP) : YW'(1);
    nx       = ox + stx;
    ny       = oy + sty;
    tpl_end  = (tx == TXW'(TPL_W - 1)) && (ty == TYW'(TPL_H - 1));
    row_end  = (nx > xhi);
    grid_end = row_end && (ny > yhi);
  end

  // fine window centred on the coarse winner, clipped to legal offsets
  always_comb begin
    int lo_x, hi_x, lo_y, hi_y;
    lo_x = int'(best_x) - FINE_RAD;
    hi_x = int'(best_x) + FINE_RAD;
    lo_y = int'(best_y) - FINE_RAD;
    hi_y = int'(best_y) + FINE_RAD;
    if (lo_x < 0) lo_x = 0;
    if (lo_y < 0) lo_y = 0;
    if (hi_x > MAX_OX) hi_x = MAX_OX;
    if (hi_y > MAX_OY) hi_y = MAX_OY;
    fxlo = XW'(lo_x);
    fxhi = XW'(hi_x);
    fylo = YW'(lo_y);
    fyhi = YW'(hi_y);
  end

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign clr      = (st == ST_IDLE) && start;
  assign seal     = (st == ST_FDRAIN) && (dcnt == 2'(DRAIN_LAST));
  assign iss_vld  = issuing;
  assign iss_last = tpl_end;
  assign iss_x    = ox;
  assign iss_y    = oy;
  assign img_addr = IAW'((int'(oy) + int'(ty)) * IMG_W + int'(ox) + int'(tx));
  assign tpl_addr = TAW'(int'(ty) * TPL_W + int'(tx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ox   <= '0;
      oy   <= '0;
      tx   <= '0;
      ty   <= '0;
      xlo  <= '0;
      xhi  <= '0;
      yhi  <= '0;
      dcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            ox  <= '0;
            oy  <= '0;
            tx  <= '0;
            ty  <= '0;
            xlo <= '0;
            xhi <= XW'(MAX_OX);
            yhi <= YW'(MAX_OY);
            st  <= ST_COARSE;
          end
        end
        ST_COARSE, ST_FINE: begin
          if (tpl_end) begin
            tx <= '0;
            ty <= '0;
            if (row_end) begin
              ox <= xlo;
              if (grid_end) begin
                dcnt <= '0;
                st   <= coarse ? ST_CDRAIN : ST_FDRAIN;
              end else begin
                oy <= ny;
              end
            end else begin
              ox <= nx;
            end
          end else if (tx == TXW'(TPL_W - 1)) begin
            tx <= '0;
            ty <= ty + 1'b1;
          end else begin
            tx <= tx + 1'b1;
          end
        end
        ST_CDRAIN: begin
          if (dcnt == 2'(DRAIN_LAST)) begin
            xlo <= fxlo;
            xhi <= fxhi;
            yhi <= fyhi;
            ox  <= fxlo;
            oy  <= fylo;
            st  <= ST_FINE;
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        ST_FDRAIN: begin
          if (dcnt == 2'(DRAIN_LAST)) st <= ST_DONE;
          else dcnt <= dcnt + 1'b1;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tmatch_mac.sv
module tmatch_mac
  import tmatch_pkg::*;
#(
  parameter int ACC_W = 20,
  parameter int XW = 5,
  parameter int YW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_vld,
  input  logic             iss_last,
  input  logic [XW-1:0]    iss_x,
  input  logic [YW-1:0]    iss_y,
  input  logic [PIX_W-1:0] img_px,
  input  logic [PIX_W-1:0] tpl_px,
  output logic             sc_vld,
  output logic [ACC_W-1:0] sc_val,
  output logic [XW-1:0]    sc_x,
  output logic [YW-1:0]    sc_y
);
  logic             v1, l1;
  logic [XW-1:0]    x1;
  logic [YW-1:0]    y1;
  logic [ACC_W-1:0] acc, sum;
  logic [2*PIX_W-1:0] prod;

  always_comb begin
    prod = {{PIX_W{1'b0}}, img_px} * {{PIX_W{1'b0}}, tpl_px};
    sum  = acc + ACC_W'(prod);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1     <= 1'b0;
      l1     <= 1'b0;
      x1     <= '0;
      y1     <= '0;
      acc    <= '0;
      sc_vld <= 1'b0;
      sc_val <= '0;
      sc_x   <= '0;
      sc_y   <= '0;
    end else begin
      // align the offset tag with the read data that returns one cycle later
      v1     <= iss_vld;
      l1     <= iss_last;
      x1     <= iss_x;
      y1     <= iss_y;
      sc_vld <= 1'b0;
      if (v1) begin
        if (l1) begin
          acc    <= '0;
          sc_val <= sum;
          sc_x   <= x1;
          sc_y   <= y1;
          sc_vld <= 1'b1;
        end else begin
          acc <= sum;
        end
      end
    end
  end
endmodule

// File: rtl/tmatch_peak.sv
module tmatch_peak #(
  parameter int ACC_W = 20,
  parameter int XW = 5,
  parameter int YW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] thr_in,
  input  logic             seal,
  input  logic             sc_vld,
  input  logic [ACC_W-1:0] sc_val,
  input  logic [XW-1:0]    sc_x,
  input  logic [YW-1:0]    sc_y,
  output logic [XW-1:0]    best_x,
  output logic [YW-1:0]    best_y,
  output logic [ACC_W-1:0] peak,
  output logic             match
);
  logic [ACC_W-1:0] thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_x <= '0;
      best_y <= '0;
      peak   <= '0;
      match  <= 1'b0;
      thr_q  <= '0;
    end else if (clr) begin
      best_x <= '0;
      best_y <= '0;
      peak   <= '0;
      match  <= 1'b0;
      thr_q  <= thr_in;
    end else begin
      // strict compare: an equal later score keeps the earlier offset
      if (sc_vld && (sc_val > peak)) begin
        best_x <= sc_x;
        best_y <= sc_y;
        peak   <= sc_val;
      end
      if (seal) match <= (peak >= thr_q);
    end
  end
endmodule

// File: rtl/tmatch_top.sv
module tmatch_top
  import tmatch_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int IMG_H = 12,
  parameter int TPL_W = 4,
  parameter int TPL_H = 3,
  parameter int COARSE_STEP = 4,
  parameter int FINE_RAD = 2,
  localparam int ACC_W = 16 + $clog2(TPL_W * TPL_H + 1),
  localparam int XW = $clog2(IMG_W + COARSE_STEP + FINE_RAD + 1),
  localparam int YW = $clog2(IMG_H + COARSE_STEP + FINE_RAD + 1),
  localparam int IAW = $clog2(IMG_W * IMG_H),
  localparam int TAW = $clog2(TPL_W * TPL_H)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [ACC_W-1:0] match_thresh,
  output logic             busy,
  output logic             done,
  output logic [IAW-1:0]   img_addr,
  input  logic [7:0]       img_data,
  output logic [TAW-1:0]   tpl_addr,
  input  logic [7:0]       tpl_data,
  output logic [XW-1:0]    best_x,
  output logic [YW-1:0]    best_y,
  output logic [ACC_W-1:0] peak,
  output logic             match
);
  logic             clr, seal, iss_vld, iss_last, sc_vld;
  logic [XW-1:0]    iss_x, sc_x;
  logic [YW-1:0]    iss_y, sc_y;
  logic [ACC_W-1:0] sc_val;

  tmatch_scan #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .TPL_W(TPL_W), .TPL_H(TPL_H),
    .COARSE_STEP(COARSE_STEP), .FINE_RAD(FINE_RAD),
    .XW(XW), .YW(YW), .IAW(IAW), .TAW(TAW)
  ) u_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .best_x(best_x), .best_y(best_y),
    .busy(busy), .done(done), .clr(clr), .seal(seal),
    .iss_vld(iss_vld), .iss_last(iss_last), .iss_x(iss_x), .iss_y(iss_y),
    .img_addr(img_addr), .tpl_addr(tpl_addr)
  );

  tmatch_mac #(.ACC_W(ACC_W), .XW(XW), .YW(YW)) u_mac (
    .clk(clk), .rst_n(rst_n),
    .iss_vld(iss_vld), .iss_last(iss_last), .iss_x(iss_x), .iss_y(iss_y),
    .img_px(img_data), .tpl_px(tpl_data),
    .sc_vld(sc_vld), .sc_val(sc_val), .sc_x(sc_x), .sc_y(sc_y)
  );

  tmatch_peak #(.ACC_W(ACC_W), .XW(XW), .YW(YW)) u_peak (
    .clk(clk), .rst_n(rst_n), .clr(clr), .thr_in(match_thresh), .seal(seal),
    .sc_vld(sc_vld), .sc_val(sc_val), .sc_x(sc_x), .sc_y(sc_y),
    .best_x(best_x), .best_y(best_y), .peak(peak), .match(match)
  );
endmodule

// File: rtl/tmatch_chk.sv
module tmatch_chk #(
  parameter int IMG_N = 192,
  parameter int TPL_N = 12,
  parameter int ACC_W = 20,
  parameter int XW = 5,
  parameter int YW = 5,
  parameter int IAW = 8,
  parameter int TAW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [IAW-1:0]   img_addr,
  input logic [TAW-1:0]   tpl_addr,
  input logic [XW-1:0]    best_x,
  input logic [YW-1:0]    best_y,
  input logic [ACC_W-1:0] peak,
  input logic             match
);
  // R8: completion is a single-cycle pulse inside the busy interval
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r8_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7: a start in the done cycle does not launch another search
  a_r7_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R9: results frozen while idle and no start arrives
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(best_x) && $stable(best_y) &&
                           $stable(peak) && $stable(match)));
  // R5: running maximum never decreases during a search
  a_r5_peak_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (peak >= $past(peak)));
  // R2: addresses stay inside both memories
  a_r2_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((int'(img_addr) < IMG_N) && (int'(tpl_addr) < TPL_N)));
endmodule

bind tmatch_top tmatch_chk #(
  .IMG_N(IMG_W * IMG_H), .TPL_N(TPL_W * TPL_H),
  .ACC_W(ACC_W), .XW(XW), .YW(YW), .IAW(IAW), .TAW(TAW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .img_addr(img_addr), .tpl_addr(tpl_addr),
  .best_x(best_x), .best_y(best_y), .peak(peak), .match(match)
);

// File: tb/tb_tmatch_top.sv
module tb_tmatch_top;
  localparam int CLK_PERIOD = 10;
  localparam int IMG_W = 16, IMG_H = 12, TPL_W = 4, TPL_H = 3;
  localparam int STEP = 4, RAD = 2;
  localparam int IMG_N = IMG_W * IMG_H, TPL_N = TPL_W * TPL_H;
  localparam int MOX = IMG_W - TPL_W, MOY = IMG_H - TPL_H;
  localparam int ACC_W = 16 + $clog2(TPL_N + 1);
  localparam int XW = $clog2(IMG_W + STEP + RAD + 1);
  localparam int YW = $clog2(IMG_H + STEP + RAD + 1);
  localparam int IAW = $clog2(IMG_N), TAW = $clog2(TPL_N);

  logic clk = 0, rst_n = 0, start = 0;
  logic [ACC_W-1:0] match_thresh = '0;
  logic busy, done, match;
  logic [IAW-1:0] img_addr;
  logic [TAW-1:0] tpl_addr;
  logic [7:0] img_data, tpl_data;
  logic [XW-1:0] best_x;
  logic [YW-1:0] best_y;
  logic [ACC_W-1:0] peak;
  logic [7:0] img_m [IMG_N];
  logic [7:0] tpl_m [TPL_N];
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmatch_top #(.IMG_W(IMG_W), .IMG_H(IMG_H), .TPL_W(TPL_W), .TPL_H(TPL_H),
               .COARSE_STEP(STEP), .FINE_RAD(RAD)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .match_thresh(match_thresh),
    .busy(busy), .done(done), .img_addr(img_addr), .img_data(img_data),
    .tpl_addr(tpl_addr), .tpl_data(tpl_data), .best_x(best_x),
    .best_y(best_y), .peak(peak), .match(match));

  // R2: row-major memories with one cycle of read latency
  always @(posedge clk) begin
    img_data <= img_m[img_addr];
    tpl_data <= tpl_m[tpl_addr];
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint score(int ox, int oy);
    longint s = 0;
    for (int v = 0; v < TPL_H; v++)
      for (int u = 0; u < TPL_W; u++)
        s += longint'(img_m[(oy + v) * IMG_W + ox + u]) * longint'(tpl_m[v * TPL_W + u]);
    return s;
  endfunction

  // R3/R4/R5 reference: coarse grid, clipped fine window, strict replacement
  task automatic model(output int bx, output int by, output longint bp,
                       output int nc, output int nf);
    int lx, hx, ly, hy;
    longint s;
    bx = 0; by = 0; bp = 0; nc = 0; nf = 0;
    for (int y = 0; y <= MOY; y += STEP)
      for (int x = 0; x <= MOX; x += STEP) begin
        s = score(x, y); nc++;
        if (s > bp) begin bp = s; bx = x; by = y; end
      end
    lx = (bx - RAD < 0) ? 0 : bx - RAD;
    hx = (bx + RAD > MOX) ? MOX : bx + RAD;
    ly = (by - RAD < 0) ? 0 : by - RAD;
    hy = (by + RAD > MOY) ? MOY : by + RAD;
    for (int y = ly; y <= hy; y++)
      for (int x = lx; x <= hx; x++) begin
        s = score(x, y); nf++;
        if (s > bp) begin bp = s; bx = x; by = y; end
      end
  endtask

  // start a search; a second start pulse is placed in cycle extra_at if > 0
  task automatic run(input longint thr, input int extra_at, output int lat);
    @(negedge clk);
    start = 1; match_thresh = ACC_W'(thr);
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done && lat < 5000) begin
      start = (lat == extra_at);
      @(negedge clk);
      lat++;
    end
    start = 0;
    if (lat >= 5000) chk(0, "watchdog", lat, 0);
  endtask

  task automatic full_check(input string tag, input longint thr, input int extra_at,
                            output int lat);
    int bx, by, nc, nf;
    longint bp;
    model(bx, by, bp, nc, nf);
    run(thr, extra_at, lat);
    chk(lat == TPL_N * (nc + nf) + 7, {tag, " R3 R4 latency"}, lat, TPL_N * (nc + nf) + 7);
    chk(int'(best_x) == bx, {tag, " R5 best_x"}, best_x, bx);
    chk(int'(best_y) == by, {tag, " R5 best_y"}, best_y, by);
    chk(longint'(peak) == bp, {tag, " R1 peak"}, peak, bp);
    chk(match == (bp >= thr), {tag, " R6 match"}, match, (bp >= thr));
    @(negedge clk);
    chk(!done && !busy, {tag, " R8 done single"}, {done, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lat, lat_ref;
    int hx, hy;
    longint hp;
    logic hm;
    int seed = 12345;
    for (int i = 0; i < IMG_N; i++) img_m[i] = 0;
    for (int i = 0; i < TPL_N; i++) tpl_m[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done, "R10 busy/done", {busy, done}, 0);
    chk(best_x == 0 && best_y == 0, "R10 offset", {best_x, best_y}, 0);
    chk(peak == 0 && !match, "R10 peak/match", peak, 0);
    rst_n = 1;
    @(negedge clk);

    // all-zero pictures: every score ties at 0, threshold 0 matches
    full_check("zero", 0, 0, lat);
    full_check("zero-thr1", 1, 0, lat);

    // R1 saturated: 255 everywhere, largest possible sum, tie keeps (0,0)
    for (int i = 0; i < IMG_N; i++) img_m[i] = 8'd255;
    for (int i = 0; i < TPL_N; i++) tpl_m[i] = 8'd255;
    full_check("sat", 255 * 255 * TPL_N, 0, lat);
    chk(peak == ACC_W'(255 * 255 * TPL_N), "R1 no wrap", peak, 255 * 255 * TPL_N);

    // pseudo-random pictures
    for (int i = 0; i < IMG_N; i++) begin seed = seed * 1103515245 + 12345; img_m[i] = 8'(seed >>> 16); end
    for (int i = 0; i < TPL_N; i++) begin seed = seed * 1103515245 + 12345; tpl_m[i] = 8'(seed >>> 16); end
    full_check("rand", 64'h7FFFF, 0, lat_ref);
    // R7: start in mid-run is ignored, latency and result unchanged
    full_check("rand-midstart", 64'h7FFFF, 40, lat);
    chk(lat == lat_ref, "R7 mid start latency", lat, lat_ref);

    // R6 threshold exactly at the peak, then one above
    hp = longint'(peak);
    full_check("rand-thr-eq", hp, 0, lat);
    full_check("rand-thr-up", hp + 1, 0, lat);

    // planted template at a non-grid spot and at the far corner (clipping)
    for (int i = 0; i < TPL_N; i++) tpl_m[i] = 8'((i * 37 + 11) % 256);
    for (int i = 0; i < IMG_N; i++) img_m[i] = 8'd3;
    for (int v = 0; v < TPL_H; v++)
      for (int u = 0; u < TPL_W; u++) img_m[(5 + v) * IMG_W + 6 + u] = tpl_m[v * TPL_W + u];
    full_check("plant-mid", 1000, 0, lat);
    for (int i = 0; i < IMG_N; i++) img_m[i] = 8'd2;
    for (int v = 0; v < TPL_H; v++)
      for (int u = 0; u < TPL_W; u++) img_m[(MOY + v) * IMG_W + MOX + u] = tpl_m[v * TPL_W + u];
    full_check("plant-corner", 1000, 0, lat_ref);

    // R7 + R9: start raised in the very cycle done is high
    @(negedge clk);
    start = 1; match_thresh = '0;
    @(negedge clk);
    start = 0;
    for (int k = 1; k < lat_ref; k++) @(negedge clk);
    chk(done == 1'b1, "R4 done at predicted cycle", done, 1);
    hx = best_x; hy = best_y; hp = peak; hm = match;
    start = 1;
    @(negedge clk);
    start = 0;
    chk(!busy, "R7 start at done dropped", busy, 0);
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      if (done || busy) chk(0, "R7 no new search", {done, busy}, 0);
    end
    chk(int'(best_x) == hx && int'(best_y) == hy, "R9 offset held", {best_x, best_y}, {hx[XW-1:0], hy[YW-1:0]});
    chk(longint'(peak) == hp && match == hm, "R9 peak/match held", peak, hp);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule